// File: doc/BRIEF.md
# SYSREF Capture Tap Picker

This block chooses a capture tap for a SYSREF sampler from a position status word. Bit i of the word stands for candidate sampling position i. A 1 marks a position with a setup or hold risk, and a 0 marks a safe position. A request pulse starts a scan. The block walks the first 16 positions, one bit per clock. It reports the midpoint of the widest run of safe positions as a 4-bit tap, together with a step-size (zoom) control taken from the full 24-bit word.

When two devices must share one tap, the second device's status word is ORed into the first. The chosen tap is then safe on both devices. If no safe position exists among the first 16, the block raises an error flag and keeps its previous tap.

Top module: `sysref_tap_picker`

## Requirements
- R1: After reset, tap_sel is 0, zoom is 1, and sel_valid, sel_err and done are 0.
- R2: A start pulse seen while idle begins a scan. done goes high for exactly one cycle, 16 clock edges after the edge that captured start.
- R3: The status inputs are captured at the accepting edge, and later changes to them have no effect on the result. A start pulse during a scan is ignored.
- R4: The combined word has bit i as position i, with 1 meaning risk and 0 meaning safe. The tap is the first position of the widest run of 0 bits within positions 0..15, plus (run length - 1)/2 rounded down.
- R5: When two or more runs share the greatest width, the run that starts at the lowest position is used.
- R6: zoom is 0 when bits 0..23 of the combined word are all 1, and 1 otherwise.
- R7: If positions 0..15 are all 1, the scan ends with sel_err=1 and sel_valid=0, and tap_sel keeps its previous value. A scan that finds a safe position ends with sel_valid=1 and sel_err=0.
- R8: With pair_en=1 the combined word is status_a | status_b. With pair_en=0, status_b has no effect.
- R9: tap_sel, zoom, sel_valid and sel_err change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Scan request pulse |
| pair_en | input | 1 | Merge the second device's status word |
| status_a | input | 24 | Position status of the first device (1 = risk) |
| status_b | input | 24 | Position status of the second device (1 = risk) |
| tap_sel | output | 4 | Chosen capture tap |
| zoom | output | 1 | Step-size control |
| sel_valid | output | 1 | Last scan found a safe tap |
| sel_err | output | 1 | Last scan found no safe tap |
| done | output | 1 | One-cycle scan-complete pulse |

## Verification
A wrong run length, run start or best-run record inside the scanner shows up as a wrong tap_sel in the done cycle of the same scan. That is 16 cycles after the request. Sweeping every single safe run across positions 0..15, together with multi-run and tied patterns, brings any such fault out within one scan. A bad index or state counter shows as done arriving at the wrong cycle, or not arriving. A fault that lets outputs move at other times is caught by comparing them with their held values on every cycle of each scan.

// File: rtl/sysref_tap_picker.sv
module sysref_tap_picker #(
  parameter int W    = 24,
  parameter int TAPS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pair_en,
  input  logic [W-1:0] status_a,
  input  logic [W-1:0] status_b,
  output logic [3:0]   tap_sel,
  output logic         zoom,
  output logic         sel_valid,
  output logic         sel_err,
  output logic         done
);
  localparam int TW = $clog2(TAPS);
  localparam int LW = $clog2(TAPS + 1);

  logic [W-1:0]  word;
  logic          busy;
  logic [TW-1:0] idx, cur_start, best_start, cur_start_n, best_start_n, mid;
  logic [LW-1:0] cur_len, best_len, cur_len_n, best_len_n;
  logic          bit_clr, take, last;

  assign bit_clr      = ~word[idx];
  assign cur_len_n    = bit_clr ? cur_len + LW'(1) : '0;
  assign cur_start_n  = (bit_clr && cur_len == '0) ? idx : cur_start;
  assign take         = cur_len_n > best_len;
  assign best_len_n   = take ? cur_len_n : best_len;
  assign best_start_n = take ? cur_start_n : best_start;
  assign mid          = best_start_n + TW'((best_len_n - LW'(1)) >> 1);
  assign last         = idx == TW'(TAPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; word <= '0;
      cur_len <= '0; best_len <= '0; cur_start <= '0; best_start <= '0;
      tap_sel <= '0; zoom <= 1'b1; sel_valid <= 1'b0; sel_err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; idx <= '0;
          word <= status_a | (pair_en ? status_b : '0);
          cur_len <= '0; best_len <= '0; cur_start <= '0; best_start <= '0;
        end
      end else begin
        cur_len <= cur_len_n; cur_start <= cur_start_n;
        best_len <= best_len_n; best_start <= best_start_n;
        idx <= idx + TW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          zoom <= ~&word;
          if (best_len_n == '0) begin
            sel_err <= 1'b1; sel_valid <= 1'b0;
          end else begin
            sel_err <= 1'b0; sel_valid <= 1'b1; tap_sel <= 4'(mid);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sysref_tap_picker_chk.sv
module sysref_tap_picker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [3:0] tap_sel,
  input logic       zoom,
  input logic       sel_valid,
  input logic       sel_err,
  input logic       done
);
  logic       run;
  logic [4:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin run <= 1'b0; cnt <= '0; end
    else if (!run) begin if (start) begin run <= 1'b1; cnt <= '0; end end
    else begin cnt <= cnt + 5'd1; if (cnt == 5'd15) run <= 1'b0; end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> ($past(cnt) == 5'd15 && $past(run)));
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n) !(sel_valid && sel_err));
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n) (done && sel_err) |-> tap_sel == $past(tap_sel));
  assert_tap_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n) (tap_sel != $past(tap_sel)) |-> done);
  assert_zoom_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(zoom) && $stable(sel_valid) && $stable(sel_err));
endmodule

bind sysref_tap_picker sysref_tap_picker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .tap_sel(tap_sel), .zoom(zoom),
  .sel_valid(sel_valid), .sel_err(sel_err), .done(done)
);

// File: tb/sysref_tap_picker_tb_top.sv
`timescale 1ns/1ps
module sysref_tap_picker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pair_en = 1'b0;
  logic [23:0] status_a = '0, status_b = '0;
  logic [3:0] tap_sel;
  logic zoom, sel_valid, sel_err, done;
  int errors = 0, checks = 0;
  logic [3:0] exp_tap = 4'd0;
  logic exp_zoom = 1'b1, exp_valid = 1'b0, exp_err = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  sysref_tap_picker dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [23:0] w);
    int bl = 0, bs = 0, cl = 0, cs = 0;
    for (int i = 0; i < 16; i++) begin
      if (!w[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    exp_zoom = ~&w;
    if (bl == 0) begin exp_err = 1'b1; exp_valid = 1'b0; end
    else begin exp_err = 1'b0; exp_valid = 1'b1; exp_tap = 4'(bs + (bl - 1) / 2); end
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic scan(input logic [23:0] a, input logic [23:0] b, input logic pe,
                      input string req, input bit disturb);
    int k;
    logic [3:0] pt = tap_sel;
    logic pz = zoom, pv = sel_valid, pr = sel_err;
    status_a = a; status_b = b; pair_en = pe;
    model(a | (pe ? b : 24'h0));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 40) begin
      k++;
      if (disturb && k == 3) begin start = 1'b1; status_a = ~a; status_b = ~b; pair_en = ~pe; end
      if (disturb && k == 4) start = 1'b0;
      @(negedge clk);
      if (!done) begin
        checks++;
        if (tap_sel != pt || zoom != pz || sel_valid != pv || sel_err != pr) begin
          errors++;
          $display("FAIL R9 outputs moved before done actual=%0d expected=%0d", {tap_sel, zoom, sel_valid, sel_err}, {pt, pz, pv, pr});
        end
      end
    end
    chk({"R2 latency ", req}, k, 16);
    chk({req, " tap"}, tap_sel, exp_tap);
    chk({"R6 zoom ", req}, zoom, exp_zoom);
    chk({req, " valid"}, sel_valid, exp_valid);
    chk({req, " err"}, sel_err, exp_err);
    @(negedge clk);
    chk("R2 done one cycle", done, 0);
    start = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tap", tap_sel, 0); chk("R1 zoom", zoom, 1);
    chk("R1 valid", sel_valid, 0); chk("R1 err", sel_err, 0); chk("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 single safe run at every start and length
    for (int s = 0; s < 16; s++)
      for (int l = 1; s + l <= 16; l++) begin
        logic [23:0] w = 24'hFFFFFF;
        for (int j = s; j < s + l; j++) w[j] = 1'b0;
        scan(w, 24'h0, 1'b0, "R4 single run", 1'b0);
      end
    // R5 ties: equal runs 1..3 and 9..11 -> lower run, tap 2
    scan(24'hFFF1F1, 24'h0, 1'b0, "R5 tie", 1'b0);
    chk("R5 tie tap value", tap_sel, 2);
    scan(24'hFF0F0F ^ 24'h00F0F0, 24'h0, 1'b0, "R5 tie alt", 1'b0);
    // R7 all risky in 0..15: tap held, zoom 1 because bit 16 clear
    scan(24'h00FFFF ^ 24'h003C00, 24'h0, 1'b0, "R4 setup", 1'b0);
    scan(24'hFEFFFF, 24'h0, 1'b0, "R7 no tap", 1'b0);
    chk("R7 held tap", tap_sel, 11);
    // R6 all 24 set -> zoom 0
    scan(24'hFFFFFF, 24'h0, 1'b0, "R6 R7 saturated", 1'b0);
    chk("R6 zoom zero", zoom, 0);
    // R8 pair merge and ignore
    scan(24'hFFF00F, 24'h0FFFFF, 1'b1, "R8 paired", 1'b0);
    scan(24'hFF0000, 24'hFFFFFF, 1'b0, "R8 b ignored", 1'b0);
    chk("R8 b ignored tap", tap_sel, 7);
    scan(24'h0F00F0, 24'h8000FF, 1'b1, "R8 paired 2", 1'b0);
    // R3 disturbance during scan
    scan(24'hFFC03F, 24'h0, 1'b0, "R3 disturb", 1'b1);
    scan(24'h123456, 24'h0F0F00, 1'b1, "R3 disturb 2", 1'b1);
    // random patterns
    for (int n = 0; n < 200; n++) begin
      logic [23:0] ra, rb;
      rng = nxt(rng); ra = rng[23:0];
      rng = nxt(rng); rb = rng[23:0];
      scan(ra | (n[0] ? 24'h0 : 24'h00AA00), rb, n[1], "R4 R5 R8 random", 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule